// File: doc/BRIEF.md
# Reset and Boot Configuration Sequencer

This block controls reset and start-up for a programmable clock device. Two sources can hold the device in reset: an internal power-on reset level and an active-low external reset pin. The external pin is synchronized and filtered for a minimum width. While either source is active, the register file, the error flag and the sequencer are all held at their defaults. The clock outputs stay dark, the interrupt line is released and the serial slave port gives no response.

When the later of the two reset sources lets go, the sequencer first copies an initial block of registers from the one-time-programmable image. Register 0 of that block then selects how the remaining registers are filled: from the OTP image, from an external EEPROM read over a request/acknowledge handshake, from both in that order, or from neither. Only when loading is finished does the block open the slave port, assert its lock request and drive the output enables from the map that the two select pins choose.

Top module: `bootSequencer`

## Requirements
- R1: While `porActive` is high or the filtered external reset is active, `lockReq`, `eeReq`, `spAck`, `cfgErr` and `outEn` are 0 and `intN` is 1. Every register returns to 0, which is visible after a later load that writes only part of the file.
- R2: `rstInN` is passed through two synchronizing flops. A low level lasting at least MIN_PULSE (3) clocks resets the block. A shorter low pulse changes nothing: `lockReq` stays high and register contents written through the slave port are kept.
- R3: Loading starts only once both reset sources are inactive. If `porActive` falls while `rstInN` is still low, no load step happens until `rstInN` rises.
- R4: Registers 0 to INIT_WORDS-1 (0 to 3) are always loaded first from `otpImage`, where register k is the byte at bits 8k+7 to 8k.
- R5: Bit 0 of register 0 requests the remaining registers from `otpImage` and bit 1 requests them from the EEPROM. When both bits are 0, the remaining registers keep the value 0.
- R6: When both bits are set, the OTP words are applied first and the EEPROM words second, so the EEPROM values are the ones kept.
- R7: During the EEPROM phase, `eeReq` stays high and `eeAddr` is held stable until `eeAck`. The addresses run in ascending order from INIT_WORDS to NUM_REGS-1, and `eeData` is captured in the cycle of `eeAck`.
- R8: When `eeAck` arrives with `eeErr` high, the word is discarded, loading ends and `cfgErr` is set. `cfgErr` is cleared only by reset. `intN` is low exactly when `cfgErr` is set and bit 7 of register 0 is set.
- R9: Until loading is complete, `spAck` and `spRdata` are 0 and slave writes are dropped. Afterwards a read returns the addressed register in the same cycle and a write takes effect at the clock edge.
- R10: `lockReq` rises when loading completes. `phaseAdjAllow` is high only when `lockReq` and `lockInd` are both high.
- R11: After loading, `outEn` equals bits 3:0 of register 2+`gpioSel`. Before that, `outEn` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porActive | input | 1 | Internal power-on reset, active high |
| rstInN | input | 1 | External reset, active low, asynchronous |
| otpImage | input | NUM_REGS*DATA_W | OTP fuse image, byte k for register k |
| eeReq | output | 1 | EEPROM word request |
| eeAddr | output | AW | EEPROM word address |
| eeAck | input | 1 | EEPROM word acknowledge |
| eeErr | input | 1 | Error flag qualified by eeAck |
| eeData | input | DATA_W | EEPROM word |
| gpioSel | input | SEL_W | Output-enable map select |
| outEn | output | NUM_OUT | Clock output enables |
| lockInd | input | 1 | PLL lock indication |
| lockReq | output | 1 | Request to lock the PLL |
| phaseAdjAllow | output | 1 | Phase adjustment permitted |
| intN | output | 1 | Interrupt, active low (open-drain level) |
| cfgErr | output | 1 | Sticky configuration load error |
| spValid | input | 1 | Slave access strobe |
| spWrite | input | 1 | Slave access is a write |
| spAddr | input | AW | Slave register address |
| spWdata | input | DATA_W | Slave write data |
| spRdata | output | DATA_W | Slave read data |
| spAck | output | 1 | Slave access accepted |

## Verification
A sequencer stuck in the wrong state shows up at the ports within one clock. It appears as an early or missing `lockReq`, as `eeReq` asserted together with an open slave port, or as `eeAddr` moving without an acknowledge. A wrong source choice or a wrong order between OTP and EEPROM remains invisible until loading completes. It is then caught by reading back every register and by the output-enable map for each select value. A faulty reset filter shows either as a short pulse that wipes a value written by software, or as a valid pulse that fails to restart the load.

// File: rtl/bootPkg.sv
package bootPkg;
  typedef enum logic [2:0] {
    ST_HOLD, ST_INIT, ST_PICK, ST_OTP, ST_EE, ST_DONE
  } bootState_t;

  typedef struct packed {
    logic otpWr;
    logic eeWr;
    logic errSet;
    logic running;
  } bootStrobe_t;
endpackage

// File: rtl/bootRstCond.sv
module bootRstCond #(
  parameter int MIN_PULSE = 3
) (
  input  logic clk,
  input  logic porActive,
  input  logic rstInN,
  output logic sysRst
);
  localparam int CW = $clog2(MIN_PULSE + 1);

  logic sync1, sync2, extHeld;
  logic [CW-1:0] lowCnt;

  // During power-on reset the pin is treated as asserted, so the later release wins
  always_ff @(posedge clk) begin
    if (porActive) begin
      sync1   <= 1'b0;
      sync2   <= 1'b0;
      extHeld <= 1'b1;
      lowCnt  <= CW'(MIN_PULSE - 1);
    end else begin
      sync1 <= rstInN;
      sync2 <= sync1;
      if (sync2) begin
        lowCnt  <= '0;
        extHeld <= 1'b0;
      end else if (lowCnt == CW'(MIN_PULSE - 1)) begin
        extHeld <= 1'b1;
      end else begin
        lowCnt <= lowCnt + 1'b1;
      end
    end
  end

  assign sysRst = porActive | extHeld;
endmodule

// File: rtl/bootCtrl.sv
module bootCtrl
  import bootPkg::*;
#(
  parameter int NUM_REGS   = 16,
  parameter int INIT_WORDS = 4,
  localparam int AW = $clog2(NUM_REGS)
) (
  input  logic          clk,
  input  logic          sysRst,
  input  logic [1:0]    bootSrc,
  input  logic          eeAck,
  input  logic          eeErr,
  output logic          eeReq,
  output logic [AW-1:0] wrIdx,
  output bootStrobe_t   strobe
);
  localparam logic [AW-1:0] LAST_INIT  = AW'(INIT_WORDS - 1);
  localparam logic [AW-1:0] FIRST_REST = AW'(INIT_WORDS);
  localparam logic [AW-1:0] LAST_REG   = AW'(NUM_REGS - 1);
  localparam bit HAS_REST = INIT_WORDS < NUM_REGS;

  bootState_t state, stateNx;
  logic [AW-1:0] idx, idxNx;

  always_ff @(posedge clk) begin
    if (sysRst) begin
      state <= ST_HOLD;
      idx   <= '0;
    end else begin
      state <= stateNx;
      idx   <= idxNx;
    end
  end

  always_comb begin
    stateNx = state;
    idxNx   = idx;
    strobe  = '0;
    eeReq   = 1'b0;
    case (state)
      ST_HOLD: begin
        stateNx = ST_INIT;
        idxNx   = '0;
      end
      ST_INIT: begin
        strobe.otpWr = 1'b1;
        if (idx == LAST_INIT) begin
          idxNx   = FIRST_REST;
          stateNx = ST_PICK;
        end else begin
          idxNx = idx + 1'b1;
        end
      end
      ST_PICK: begin
        if (!HAS_REST)       stateNx = ST_DONE;
        else if (bootSrc[0]) stateNx = ST_OTP;
        else if (bootSrc[1]) stateNx = ST_EE;
        else                 stateNx = ST_DONE;
      end
      ST_OTP: begin
        strobe.otpWr = 1'b1;
        if (idx == LAST_REG) begin
          idxNx   = FIRST_REST;
          stateNx = bootSrc[1] ? ST_EE : ST_DONE;
        end else begin
          idxNx = idx + 1'b1;
        end
      end
      ST_EE: begin
        eeReq = 1'b1;
        if (eeAck) begin
          if (eeErr) begin
            strobe.errSet = 1'b1;
            stateNx       = ST_DONE;
          end else begin
            strobe.eeWr = 1'b1;
            if (idx == LAST_REG) stateNx = ST_DONE;
            else                 idxNx   = idx + 1'b1;
          end
        end
      end
      ST_DONE: strobe.running = 1'b1;
      default: stateNx = ST_HOLD;
    endcase
  end

  assign wrIdx = idx;
endmodule

// File: rtl/bootData.sv
module bootData
  import bootPkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 8,
  parameter int NUM_OUT  = 4,
  parameter int SEL_W    = 2,
  parameter int MAP_BASE = 2,
  parameter int IRQ_BIT  = 7,
  localparam int AW = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       sysRst,
  input  bootStrobe_t                strobe,
  input  logic [AW-1:0]              wrIdx,
  input  logic [NUM_REGS*DATA_W-1:0] otpImage,
  input  logic [DATA_W-1:0]          eeData,
  input  logic [SEL_W-1:0]           gpioSel,
  input  logic                       lockInd,
  input  logic                       spValid,
  input  logic                       spWrite,
  input  logic [AW-1:0]              spAddr,
  input  logic [DATA_W-1:0]          spWdata,
  output logic [1:0]                 bootSrc,
  output logic [DATA_W-1:0]          spRdata,
  output logic                       spAck,
  output logic [NUM_OUT-1:0]         outEn,
  output logic                       lockReq,
  output logic                       phaseAdjAllow,
  output logic                       intN,
  output logic                       cfgErr
);
  localparam int NUM_MAPS = 2 ** SEL_W;

  logic [DATA_W-1:0]  regFile [NUM_REGS];
  logic               errFlag;
  logic [NUM_OUT-1:0] mapSel [NUM_MAPS];

  always_ff @(posedge clk) begin
    if (sysRst) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
      errFlag <= 1'b0;
    end else begin
      if (strobe.otpWr) regFile[wrIdx] <= otpImage[int'(wrIdx)*DATA_W +: DATA_W];
      if (strobe.eeWr)  regFile[wrIdx] <= eeData;
      if (strobe.errSet) errFlag <= 1'b1;
      if (strobe.running && spValid && spWrite) regFile[spAddr] <= spWdata;
    end
  end

  for (genvar m = 0; m < NUM_MAPS; m++) begin : gMap
    assign mapSel[m] = regFile[MAP_BASE + m][NUM_OUT-1:0];
  end

  assign bootSrc       = regFile[0][1:0];
  assign spAck         = strobe.running & spValid;
  assign spRdata       = spAck ? regFile[spAddr] : '0;
  assign outEn         = strobe.running ? mapSel[gpioSel] : '0;
  assign lockReq       = strobe.running;
  assign phaseAdjAllow = strobe.running & lockInd;
  assign intN          = !(errFlag && regFile[0][IRQ_BIT]);
  assign cfgErr        = errFlag;
endmodule

// File: rtl/bootSequencer.sv
module bootSequencer
  import bootPkg::*;
#(
  parameter int NUM_REGS   = 16,
  parameter int INIT_WORDS = 4,
  parameter int DATA_W     = 8,
  parameter int NUM_OUT    = 4,
  parameter int SEL_W      = 2,
  parameter int MAP_BASE   = 2,
  parameter int IRQ_BIT    = 7,
  parameter int MIN_PULSE  = 3,
  localparam int AW = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       porActive,
  input  logic                       rstInN,
  input  logic [NUM_REGS*DATA_W-1:0] otpImage,
  output logic                       eeReq,
  output logic [AW-1:0]              eeAddr,
  input  logic                       eeAck,
  input  logic                       eeErr,
  input  logic [DATA_W-1:0]          eeData,
  input  logic [SEL_W-1:0]           gpioSel,
  output logic [NUM_OUT-1:0]         outEn,
  input  logic                       lockInd,
  output logic                       lockReq,
  output logic                       phaseAdjAllow,
  output logic                       intN,
  output logic                       cfgErr,
  input  logic                       spValid,
  input  logic                       spWrite,
  input  logic [AW-1:0]              spAddr,
  input  logic [DATA_W-1:0]          spWdata,
  output logic [DATA_W-1:0]          spRdata,
  output logic                       spAck
);
  logic          sysRst;
  logic [1:0]    bootSrc;
  logic [AW-1:0] wrIdx;
  bootStrobe_t   strobe;

  bootRstCond #(.MIN_PULSE(MIN_PULSE)) uRst (
    .clk(clk), .porActive(porActive), .rstInN(rstInN), .sysRst(sysRst)
  );

  bootCtrl #(.NUM_REGS(NUM_REGS), .INIT_WORDS(INIT_WORDS)) uCtrl (
    .clk(clk), .sysRst(sysRst), .bootSrc(bootSrc), .eeAck(eeAck), .eeErr(eeErr),
    .eeReq(eeReq), .wrIdx(wrIdx), .strobe(strobe)
  );

  bootData #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NUM_OUT(NUM_OUT), .SEL_W(SEL_W),
    .MAP_BASE(MAP_BASE), .IRQ_BIT(IRQ_BIT)
  ) uData (
    .clk(clk), .sysRst(sysRst), .strobe(strobe), .wrIdx(wrIdx), .otpImage(otpImage),
    .eeData(eeData), .gpioSel(gpioSel), .lockInd(lockInd), .spValid(spValid),
    .spWrite(spWrite), .spAddr(spAddr), .spWdata(spWdata), .bootSrc(bootSrc),
    .spRdata(spRdata), .spAck(spAck), .outEn(outEn), .lockReq(lockReq),
    .phaseAdjAllow(phaseAdjAllow), .intN(intN), .cfgErr(cfgErr)
  );

  assign eeAddr = wrIdx;
endmodule

// File: rtl/bootSequencerChk.sv
module bootSequencerChk #(
  parameter int INIT_WORDS = 4,
  parameter int AW         = 4,
  parameter int NUM_OUT    = 4
) (
  input logic               clk,
  input logic               sysRst,
  input logic               eeReq,
  input logic               eeAck,
  input logic [AW-1:0]      eeAddr,
  input logic               spAck,
  input logic               lockReq,
  input logic               lockInd,
  input logic               phaseAdjAllow,
  input logic               cfgErr,
  input logic [NUM_OUT-1:0] outEn
);
  AST_PORT_SHUT_LOADING: assert property (@(posedge clk) disable iff (sysRst)
    eeReq |-> !spAck && !lockReq); // R9
  AST_OUTPUTS_DARK: assert property (@(posedge clk) disable iff (sysRst)
    !lockReq |-> outEn == '0); // R11
  AST_EE_ADDR_HELD: assert property (@(posedge clk) disable iff (sysRst)
    eeReq && !eeAck |=> eeReq && $stable(eeAddr)); // R7
  AST_EE_ADDR_RANGE: assert property (@(posedge clk) disable iff (sysRst)
    eeReq |-> eeAddr >= AW'(INIT_WORDS)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (sysRst)
    cfgErr |=> cfgErr); // R8
  AST_PHASE_GATED: assert property (@(posedge clk) disable iff (sysRst)
    phaseAdjAllow |-> lockInd && lockReq); // R10
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (sysRst)
    lockReq |=> lockReq); // R10
endmodule

bind bootSequencer bootSequencerChk #(
  .INIT_WORDS(INIT_WORDS), .AW(AW), .NUM_OUT(NUM_OUT)
) chk (
  .clk(clk), .sysRst(sysRst), .eeReq(eeReq), .eeAck(eeAck), .eeAddr(eeAddr),
  .spAck(spAck), .lockReq(lockReq), .lockInd(lockInd), .phaseAdjAllow(phaseAdjAllow),
  .cfgErr(cfgErr), .outEn(outEn)
);

// File: tb/bootSequencer_test.sv
`timescale 1ns/1ps
module bootSequencer_test;
  localparam int NUM_REGS = 16, INIT_WORDS = 4, DATA_W = 8, MAP_BASE = 2;
  localparam int AW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic porActive = 1'b1, rstInN = 1'b1;
  logic [NUM_REGS*DATA_W-1:0] otpImage = '0;
  logic eeReq, eeAck = 1'b0, eeErr = 1'b0;
  logic [AW-1:0] eeAddr;
  logic [DATA_W-1:0] eeData = '0;
  logic [1:0] gpioSel = '0;
  logic [3:0] outEn;
  logic lockInd = 1'b0, lockReq, phaseAdjAllow, intN, cfgErr;
  logic spValid = 1'b0, spWrite = 1'b0;
  logic [AW-1:0] spAddr = '0;
  logic [DATA_W-1:0] spWdata = '0, spRdata;
  logic spAck;

  bootSequencer uut (
    .clk(clk), .porActive(porActive), .rstInN(rstInN), .otpImage(otpImage),
    .eeReq(eeReq), .eeAddr(eeAddr), .eeAck(eeAck), .eeErr(eeErr), .eeData(eeData),
    .gpioSel(gpioSel), .outEn(outEn), .lockInd(lockInd), .lockReq(lockReq),
    .phaseAdjAllow(phaseAdjAllow), .intN(intN), .cfgErr(cfgErr), .spValid(spValid),
    .spWrite(spWrite), .spAddr(spAddr), .spWdata(spWdata), .spRdata(spRdata), .spAck(spAck)
  );

  int checks = 0, fails = 0;
  int errAddr = 255, waitLeft = 0, ackCount = 0, nextAddr = INIT_WORDS;
  bit orderOk = 1'b1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] otpByte(int k, logic [7:0] r0);
    return (k == 0) ? r0 : 8'(k * 37 + 5);
  endfunction
  function automatic logic [7:0] eeByte(int a);
    return 8'(8'hA0 + a);
  endfunction
  function automatic logic [7:0] expReg(int k, logic [7:0] r0, int eA);
    if (k < INIT_WORDS) return otpByte(k, r0);
    if (r0[1] && k < eA) return eeByte(k);
    if (r0[0]) return otpByte(k, r0);
    return 8'h00;
  endfunction
  function automatic bit expErr(logic [7:0] r0, int eA);
    return r0[1] && eA >= INIT_WORDS && eA < NUM_REGS;
  endfunction

  // EEPROM model: acknowledges after a per-address delay, checks ascending order (R7)
  initial begin
    forever begin
      @(negedge clk);
      eeAck = 1'b0; eeErr = 1'b0;
      if (eeReq) begin
        if (waitLeft > 0) waitLeft--;
        else begin
          if (int'(eeAddr) != nextAddr) orderOk = 1'b0;
          nextAddr++;
          ackCount++;
          eeAck  = 1'b1;
          eeData = eeByte(int'(eeAddr));
          eeErr  = (int'(eeAddr) == errAddr);
          waitLeft = int'(eeAddr) % 3;
        end
      end
    end
  end

  task automatic setImage(input logic [7:0] r0);
    for (int k = 0; k < NUM_REGS; k++) otpImage[k*8 +: 8] = otpByte(k, r0);
  endtask

  task automatic startRun(input logic [7:0] r0, input int eA);
    @(negedge clk);
    porActive = 1'b1;
    setImage(r0);
    errAddr = eA; ackCount = 0; nextAddr = INIT_WORDS; orderOk = 1'b1; waitLeft = 0;
    repeat (3) @(negedge clk);
    porActive = 1'b0;
  endtask

  // Waits for the end of loading while probing the slave port (R9)
  task automatic waitDone(output bit shutOk);
    shutOk = 1'b1;
    for (int n = 0; n < 400 && !lockReq; n++) begin
      spValid = 1'b1; spWrite = 1'b0; spAddr = 4'd0;
      #1;
      if (!lockReq && (spAck || spRdata != 0 || outEn != 0)) shutOk = 1'b0;
      @(negedge clk);
    end
    spValid = 1'b0;
  endtask

  task automatic readReg(input int a, output logic [7:0] d, output logic ack);
    @(negedge clk);
    spValid = 1'b1; spWrite = 1'b0; spAddr = AW'(a);
    #1; d = spRdata; ack = spAck;
    @(negedge clk);
    spValid = 1'b0;
  endtask

  task automatic writeReg(input int a, input logic [7:0] d);
    @(negedge clk);
    spValid = 1'b1; spWrite = 1'b1; spAddr = AW'(a); spWdata = d;
    @(negedge clk);
    spValid = 1'b0; spWrite = 1'b0;
  endtask

  // Vector: {register 0 image, EEPROM error address (255 = none)}
  localparam logic [15:0] VEC [7] = '{
    {8'h01, 8'd255}, {8'h00, 8'd255}, {8'h02, 8'd255}, {8'h03, 8'd255},
    {8'h82, 8'd9},   {8'h83, 8'd4},   {8'h02, 8'd12}
  };

  task automatic runVector(input logic [7:0] r0, input int eA);
    bit shutOk;
    logic [7:0] d;
    logic ack;
    startRun(r0, eA);
    waitDone(shutOk);
    check(lockReq === 1'b1, "R10", "lockReq after load", 32'(lockReq), 1);
    check(shutOk, "R9", "port shut and outputs dark during load", 32'(shutOk), 1);
    for (int k = 0; k < NUM_REGS; k++) begin
      readReg(k, d, ack);
      check(ack === 1'b1 && d === expReg(k, r0, eA),
            k < INIT_WORDS ? "R4" : ((r0[1] && r0[0]) ? "R6" : "R5"),
            $sformatf("reg %0d mode %0h", k, r0), 32'(d), 32'(expReg(k, r0, eA)));
    end
    check(cfgErr === expErr(r0, eA), "R8", "cfgErr", 32'(cfgErr), 32'(expErr(r0, eA)));
    check(intN === !(expErr(r0, eA) && r0[7]), "R8", "intN", 32'(intN),
          32'(!(expErr(r0, eA) && r0[7])));
    if (r0[1]) begin
      int expAcks = expErr(r0, eA) ? eA - INIT_WORDS + 1 : NUM_REGS - INIT_WORDS;
      check(orderOk && ackCount == expAcks, "R7", "EEPROM address sequence",
            32'(ackCount), 32'(expAcks));
    end
    for (int g = 0; g < 4; g++) begin
      @(negedge clk); gpioSel = 2'(g); #1;
      check(outEn === expReg(MAP_BASE + g, r0, eA)[3:0], "R11",
            $sformatf("outEn map %0d", g), 32'(outEn), 32'(expReg(MAP_BASE + g, r0, eA)[3:0]));
    end
    @(negedge clk); lockInd = 1'b0; #1;
    check(phaseAdjAllow === 1'b0, "R10", "phase gate without lock", 32'(phaseAdjAllow), 0);
    @(negedge clk); lockInd = 1'b1; #1;
    check(phaseAdjAllow === 1'b1, "R10", "phase gate with lock", 32'(phaseAdjAllow), 1);
    @(negedge clk); lockInd = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit shutOk, seenDrop, seenEe;
    logic [7:0] d;
    logic ack;

    // R1: state held from time zero while power-on reset is high
    repeat (2) @(negedge clk);
    check(!lockReq && !eeReq && !spAck && !cfgErr && outEn == 0 && intN,
          "R1", "idle outputs in power-on reset",
          {lockReq, eeReq, spAck, cfgErr, outEn, intN}, 32'h1);

    // Table walk; the 8'h00 entry after 8'h01 also shows reset clearing (R1)
    foreach (VEC[i]) runVector(VEC[i][15:8], int'(VEC[i][7:0]));

    // R1: power-on reset asserted while running the erroring configuration
    @(negedge clk); porActive = 1'b1;
    @(negedge clk); #1;
    check(!lockReq && !eeReq && !spAck && !cfgErr && outEn == 0 && intN,
          "R1", "outputs forced idle by reset",
          {lockReq, eeReq, spAck, cfgErr, outEn, intN}, 32'h1);

    // R2: short external pulse is ignored, software value survives
    startRun(8'h01, 255);
    waitDone(shutOk);
    writeReg(9, 8'h5A);
    @(negedge clk); rstInN = 1'b0;
    repeat (2) @(negedge clk);
    rstInN = 1'b1;
    seenDrop = 1'b0;
    for (int n = 0; n < 10; n++) begin @(negedge clk); if (!lockReq) seenDrop = 1'b1; end
    check(!seenDrop, "R2", "short pulse keeps lockReq", 32'(seenDrop), 0);
    readReg(9, d, ack);
    check(d === 8'h5A, "R2", "short pulse keeps written reg", 32'(d), 32'h5A);

    // R2: pulse of the minimum width restarts loading and clears the written value
    @(negedge clk); rstInN = 1'b0;
    repeat (3) @(negedge clk);
    rstInN = 1'b1;
    seenDrop = 1'b0;
    for (int n = 0; n < 6; n++) begin @(negedge clk); if (!lockReq) seenDrop = 1'b1; end
    check(seenDrop, "R2", "minimum pulse resets", 32'(seenDrop), 1);
    waitDone(shutOk);
    readReg(9, d, ack);
    check(d === otpByte(9, 8'h01), "R2", "reg reloaded after reset", 32'(d), 32'(otpByte(9, 8'h01)));

    // R3: power-on reset ends first, external reset still low: no loading
    @(negedge clk); porActive = 1'b1; rstInN = 1'b0; setImage(8'h02);
    errAddr = 255; ackCount = 0; nextAddr = INIT_WORDS; orderOk = 1'b1;
    repeat (3) @(negedge clk);
    porActive = 1'b0;
    seenEe = 1'b0; seenDrop = 1'b0;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      if (eeReq) seenEe = 1'b1;
      if (lockReq) seenDrop = 1'b1;
    end
    check(!seenEe && !seenDrop, "R3", "no load while external reset held",
          {seenEe, seenDrop}, 0);
    rstInN = 1'b1;

    // R9: write during the EEPROM phase is dropped and not acknowledged
    for (int n = 0; n < 100 && !eeReq; n++) @(negedge clk);
    spValid = 1'b1; spWrite = 1'b1; spAddr = 4'd15; spWdata = 8'h33;
    #1;
    check(eeReq && !spAck, "R9", "no ack during load", 32'(spAck), 0);
    @(negedge clk); spValid = 1'b0; spWrite = 1'b0;
    waitDone(shutOk);
    readReg(15, d, ack);
    check(d === eeByte(15), "R9", "write during load dropped", 32'(d), 32'(eeByte(15)));

    // R9: write after load takes effect
    writeReg(15, 8'h33);
    readReg(15, d, ack);
    check(ack && d === 8'h33, "R9", "write after load", 32'(d), 32'h33);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule